// File: doc/BRIEF.md
# Clock Trim Pulse Sequencer

This block runs beside the prescaler of a real-time clock and decides when that prescaler should add or drop an oscillator cycle, so that a known frequency error can be trimmed out. It reads an 8-bit trim word that carries a cadence select and a signed correction count. It keeps its own seconds and minutes from a one-cycle-wide 1 Hz tick. In each correction window it emits single-cycle strobes, together with a direction flag, that the prescaler consumes.

There are two cadences. The slow cadence opens a window every two hours and spends one pulse per minute. Each count is worth roughly 4.34 ppm. The fast cadence opens a window every four minutes and spends one pulse per second during the first minute of the window. Each count is worth roughly 4.069 ppm. When more than 60 fast pulses are asked for, the extra pulses are packed into the last second of that first minute. They go out as a back-to-back burst directly after that second's regular pulse. The trim word is captured only when a window opens.

Top module: `trim_pulse_sequencer`

## Requirements
- R1: `trim_word[7]` selects the cadence: 0 is slow and 1 is fast. `trim_word[6:0]` is a two's complement count in the range -64..+63. A window emits exactly |count| strobes. `trim_add` is 1 during strobes of a non-negative count and 0 during strobes of a negative count.
- R2: A count of zero emits no strobe in its window.
- R3: Slow cadence: pulse k (0-based) is issued on the tick that begins minute k of the window, for k < |count|.
- R4: Fast cadence: pulse k is issued on the tick of second k of the window's first minute, for k < min(|count|, 60).
- R5: Fast cadence with |count| > 60: the remaining |count|-60 strobes follow the second-59 strobe on consecutive clock cycles, with no gap.
- R6: A change of `trim_word` inside a window has no effect until the next window opens.
- R7: Reset clears all counters and keeps `trim_strobe` low. The first tick after reset is second 0 of minute 0 and opens a window with the current trim word.
- R8: A strobe caused by a tick is high for exactly the one cycle after the cycle in which `sec_tick` is high.
- R9: Which window boundary comes next depends on the cadence latched for the current window. After a slow window, the next one opens only at minute 0 of the 120-minute cycle, even if the live word asks for the fast cadence. After a fast window, the next one opens at the next minute that is a multiple of 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-cycle 1 Hz tick. Consecutive ticks are at least 6 cycles apart |
| trim_word | input | 8 | Cadence select and signed correction count |
| trim_strobe | output | 1 | Correction strobe, one cycle per pulse |
| trim_add | output | 1 | Direction: 1 adds cycles, 0 removes cycles |

## Verification
If the seconds or minutes counter is wrong, pulses land on the wrong tick. Windows also open at the wrong minute, which shows up as a strobe missing at, or appearing after, the first tick of a window. A remaining-count error shows up as an extra or missing pulse before the window ends. In the fast cadence that can be at most one minute later, and in the slow cadence up to 64 minutes later. A burst-count error shows up at the second-59 tick as a burst that is too short, too long or broken up. A latched-sign or latched-cadence error shows up on the very first strobe of the next window.

// File: rtl/trim_pkg.sv
// Shared types and helpers for the trim pulse sequencer.
// Assumes the trim word is {cadence bit, two's complement count}.
package trim_pkg;

    typedef enum logic {
        MODE_SLOW = 1'b0,
        MODE_FAST = 1'b1
    } trim_mode_e;

    // Magnitude of a two's complement count. The most negative value maps to 2^(W-1).
    function automatic logic [6:0] count_mag7(input logic [6:0] c);
        return c[6] ? (~c + 7'd1) : c;
    endfunction

endpackage

// File: rtl/trim_timebase.sv
// Seconds and minutes counters driven by the 1 Hz tick.
// The counters show the slot of the coming tick. Both are zero after reset.
// The minute counter wraps at the length of the slow-cadence cycle.
module trim_timebase #(
    parameter int SECS  = 60,
    parameter int MINS  = 120,
    parameter int SEC_W = $clog2(SECS),
    parameter int MIN_W = $clog2(MINS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [SEC_W-1:0] sec,
    output logic [MIN_W-1:0] min
);
    localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SECS - 1);
    localparam logic [MIN_W-1:0] MIN_LAST = MIN_W'(MINS - 1);

    // Advance the second slot, and the minute slot on second wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec <= '0;
            min <= '0;
        end else if (tick) begin
            if (sec == SEC_LAST) begin
                sec <= '0;
                min <= (min == MIN_LAST) ? '0 : min + 1'b1;
            end else begin
                sec <= sec + 1'b1;
            end
        end
    end

    p_sec_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sec <= SEC_LAST);
    p_sec_moves_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> sec != $past(sec));
    p_sec_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(sec) && $stable(min));

endmodule

// File: rtl/trim_window.sv
// Window boundary detection and capture of the trim word.
// The boundary rule comes from the cadence of the current window.
// While a window opens, the outputs pass the fresh word through so that pulse 0 can fire on that same tick.
module trim_window #(
    parameter int SECS      = 60,
    parameter int MINS_SLOW = 120,
    parameter int MINS_FAST = 4,
    parameter int CNT_W     = 7,
    parameter int SEC_W     = $clog2(SECS),
    parameter int MIN_W     = $clog2(MINS_SLOW)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic [SEC_W-1:0]    sec,
    input  logic [MIN_W-1:0]    min,
    input  logic [CNT_W:0]      word,
    output logic                open,
    output trim_pkg::trim_mode_e mode,
    output logic [CNT_W-1:0]    mag,
    output logic                neg
);
    import trim_pkg::*;

    trim_mode_e       mode_q;
    logic [CNT_W-1:0] mag_q;
    logic             neg_q;
    logic             boundary;
    trim_mode_e       word_mode;
    logic             word_neg;
    logic [CNT_W-1:0] word_mag;

    // Decode the live word and find the boundary implied by the latched cadence.
    always_comb begin
        word_mode = trim_mode_e'(word[CNT_W]);
        word_neg  = word[CNT_W-1];
        word_mag  = word_neg ? (~word[CNT_W-1:0] + 1'b1) : word[CNT_W-1:0];
        boundary  = (sec == '0) &&
                    ((min == '0) ||
                     ((mode_q == MODE_FAST) && ((min % MIN_W'(MINS_FAST)) == '0)));
        open = tick && boundary;
        mode = open ? word_mode : mode_q;
        mag  = open ? word_mag  : mag_q;
        neg  = neg_q;
    end

    // Capture the trim word only when a window opens.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_SLOW;
            mag_q  <= '0;
            neg_q  <= 1'b0;
        end else if (open) begin
            mode_q <= word_mode;
            mag_q  <= word_mag;
            neg_q  <= word_neg;
        end
    end

    p_open_needs_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        open |-> tick && sec == '0);
    p_word_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !open |=> $stable(mode_q) && $stable(neg_q) && $stable(mag_q));

endmodule

// File: rtl/trim_pulser.sv
// Pulse scheduling inside a window: remaining count, first-minute flag and overflow burst.
// Assumes consecutive ticks are further apart than the longest burst plus one cycle.
module trim_pulser #(
    parameter int SECS  = 60,
    parameter int CNT_W = 7,
    parameter int SEC_W = $clog2(SECS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 open,
    input  trim_pkg::trim_mode_e mode,
    input  logic [CNT_W-1:0]     mag,
    input  logic [SEC_W-1:0]     sec,
    output logic                 strobe
);
    import trim_pkg::*;

    localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SECS - 1);

    logic [CNT_W-1:0] rem_q;
    logic [CNT_W-1:0] burst_q;
    logic             first_q;
    logic             strobe_q;
    logic [CNT_W-1:0] eff_rem;
    logic [CNT_W-1:0] rem_after;
    logic             eff_first;
    logic             fire;
    logic             last_sec;

    // Pick the per-tick pulse decision from the latched or freshly opened window.
    always_comb begin
        eff_rem   = open ? mag : rem_q;
        eff_first = open | first_q;
        last_sec  = (sec == SEC_LAST);
        fire      = tick && (eff_rem != '0) &&
                    ((mode == MODE_FAST) ? eff_first : (sec == '0));
        rem_after = eff_rem - CNT_W'(fire);
    end

    // Track the remaining pulses and move the fast-cadence excess into the burst counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q   <= '0;
            burst_q <= '0;
            first_q <= 1'b0;
        end else if (tick) begin
            first_q <= eff_first && !last_sec;
            if ((mode == MODE_FAST) && last_sec && fire) begin
                burst_q <= rem_after;
                rem_q   <= '0;
            end else begin
                rem_q   <= rem_after;
            end
        end else if (burst_q != '0) begin
            burst_q <= burst_q - 1'b1;
        end
    end

    // Register the strobe: a tick pulse or one step of a burst.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= fire || (burst_q != '0);
    end

    assign strobe = strobe_q;

    p_burst_fast_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        burst_q != '0 |-> mode == MODE_FAST);
    p_burst_after_last_sec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(burst_q != '0) |-> sec == '0);
    p_burst_empties_rem_r5: assert property (@(posedge clk) disable iff (!rst_n)
        burst_q != '0 |-> rem_q == '0);
    p_slow_on_minute_r3: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_q && mode == MODE_SLOW |-> sec == SEC_W'(1));
    p_no_tick_in_burst_r8: assert property (@(posedge clk) disable iff (!rst_n)
        burst_q != '0 |-> !tick);

endmodule

// File: rtl/trim_pulse_sequencer.sv
// Top level of the clock trim pulse sequencer.
// Joins the timebase, the window capture and the pulse scheduler.
// The direction flag is the sign latched for the current window.
module trim_pulse_sequencer #(
    parameter int SECS      = 60,
    parameter int MINS_SLOW = 120,
    parameter int MINS_FAST = 4,
    parameter int CNT_W     = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sec_tick,
    input  logic [CNT_W:0] trim_word,
    output logic           trim_strobe,
    output logic           trim_add
);
    import trim_pkg::*;

    localparam int SEC_W = $clog2(SECS);
    localparam int MIN_W = $clog2(MINS_SLOW);

    logic [SEC_W-1:0] sec;
    logic [MIN_W-1:0] min;
    logic             open;
    trim_mode_e       mode;
    logic [CNT_W-1:0] mag;
    logic             neg;

    trim_timebase #(.SECS(SECS), .MINS(MINS_SLOW), .SEC_W(SEC_W), .MIN_W(MIN_W)) u_time (
        .clk(clk), .rst_n(rst_n), .tick(sec_tick), .sec(sec), .min(min));

    trim_window #(.SECS(SECS), .MINS_SLOW(MINS_SLOW), .MINS_FAST(MINS_FAST),
                  .CNT_W(CNT_W), .SEC_W(SEC_W), .MIN_W(MIN_W)) u_win (
        .clk(clk), .rst_n(rst_n), .tick(sec_tick), .sec(sec), .min(min),
        .word(trim_word), .open(open), .mode(mode), .mag(mag), .neg(neg));

    trim_pulser #(.SECS(SECS), .CNT_W(CNT_W), .SEC_W(SEC_W)) u_pulse (
        .clk(clk), .rst_n(rst_n), .tick(sec_tick), .open(open), .mode(mode),
        .mag(mag), .sec(sec), .strobe(trim_strobe));

    assign trim_add = !neg;

    p_strobe_off_in_reset_r7: assert property (@(posedge clk)
        !rst_n |=> !trim_strobe);

endmodule

// File: tb/test_trim_pulse_sequencer.sv
module test_trim_pulse_sequencer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic [7:0] trim_word = 8'h00;
    logic       trim_strobe;
    logic       trim_add;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 0;

    // reference model state
    int  m_sec, m_min, m_off, m_n;
    bit  m_fast;
    bit  first_after_rst;
    bit  mid_written;

    always #2.5 clk = ~clk;

    trim_pulse_sequencer i_trim_pulse_sequencer (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .trim_word(trim_word),
        .trim_strobe(trim_strobe), .trim_add(trim_add));

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            errors++; checks++;
            $display("FAIL R8 watchdog: actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic int word_count(input logic [7:0] w);
        return w[6] ? int'(w[6:0]) - 128 : int'(w[6:0]);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; sec_tick = 1'b0;
        repeat (2) @(negedge clk);
        chk(trim_strobe == 1'b0, "R7", trim_strobe, 0);
        rst_n = 1'b1;
        m_sec = 0; m_min = 0; m_off = 0; m_n = 0; m_fast = 0;
        first_after_rst = 1; mid_written = 0;
    endtask

    // One tick: model the expected strobe pattern, then observe 7 cycles.
    task automatic do_tick();
        bit boundary;
        int mag, expn, exp_mask, obs_mask;
        bit exp_add, dir_bad;
        string tag;
        boundary = (m_sec == 0) && (m_min == 0 || (m_fast && (m_min % 4) == 0));
        if (boundary) begin
            m_fast = trim_word[7]; m_n = word_count(trim_word); m_off = 0; mid_written = 0;
        end
        mag = (m_n < 0) ? -m_n : m_n;
        expn = 0;
        if (!m_fast) begin
            if (m_sec == 0 && m_off < mag) expn = 1;
        end else if (m_off == 0) begin
            if (m_sec < mag) expn = 1;
            if (m_sec == 59 && mag > 60) expn += mag - 60;
        end
        exp_add = (m_n >= 0);
        exp_mask = (1 << expn) - 1;
        if (expn > 1) tag = "R5";
        else if (first_after_rst) tag = "R7";
        else if (!m_fast && m_sec == 0 && (m_min % 4) == 0 && m_off > 0 && trim_word[7]) tag = "R9";
        else if (mid_written) tag = "R6";
        else if (mag == 0) tag = "R2";
        else if (m_fast) tag = "R4";
        else tag = "R3";
        first_after_rst = 0;
        m_sec++;
        if (m_sec == 60) begin m_sec = 0; m_min = (m_min + 1) % 120; m_off++; end

        @(negedge clk) sec_tick = 1'b1;
        obs_mask = 0; dir_bad = 0;
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            if (i == 0) sec_tick = 1'b0;
            if (trim_strobe) begin
                obs_mask |= (1 << i);
                if (trim_add !== exp_add) dir_bad = 1;
            end
        end
        chk(obs_mask == exp_mask, tag, obs_mask, exp_mask);
        if (expn > 0) begin
            chk(obs_mask[0] == 1'b1, "R8", obs_mask[0], 1);
            chk(!dir_bad, "R1", trim_add, exp_add);
        end
    endtask

    initial begin
        logic [7:0] directed [6];
        int mid_at;
        directed[0] = 8'hC0;  // fast, -64: burst of 4, remove
        directed[1] = 8'hBF;  // fast, +63: burst of 3
        directed[2] = 8'hBD;  // fast, +61: burst of 1
        directed[3] = 8'hBC;  // fast, +60: no burst
        directed[4] = 8'h80;  // fast, 0 (R2)
        directed[5] = 8'hFF;  // fast, -1
        void'($urandom(32'd4242));

        // Phase A: fast windows with directed and random words, mid-window writes (R6)
        trim_word = directed[0];
        do_reset();
        for (int w = 0; w < 12; w++) begin
            trim_word = (w < 6) ? directed[w] : {1'b1, 7'($urandom)};
            mid_at = 10 + int'($urandom % 200);
            for (int t = 0; t < 240; t++) begin
                if (t == 1) ; // word already captured on tick 0
                if (t == mid_at) begin trim_word = 8'($urandom); mid_written = 1; end
                do_tick();
            end
        end

        // Phase B: switch to slow at a fast boundary (minute 48), then fast word mid-window (R9)
        trim_word = 8'h4E;  // slow, -50
        for (int t = 0; t < 100; t++) do_tick();
        trim_word = 8'h85;  // fast, +5 written mid-window: ignored until minute 0
        for (int t = 100; t < 72 * 60; t++) do_tick();
        for (int t = 0; t < 240; t++) do_tick();

        // Phase C: reset with slow +63 (R3, R7)
        trim_word = 8'h3F;
        do_reset();
        for (int t = 0; t < 64 * 60; t++) do_tick();

        // Phase D: reset with zero count (R2)
        trim_word = 8'h00;
        do_reset();
        for (int t = 0; t < 200; t++) do_tick();

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule